// File: doc/BRIEF.md
# Synchronous SRAM Read Output Pipeline Controller

This block drives the read-data side of a synchronous burst SRAM. Each clock edge samples a command (deselect, read or write). Data from the memory array for a read arrives during the cycle after the command is sampled. A mode input selects one of two output paths. In flow-through mode the array data goes straight to the output bus. In registered mode the data passes through one rising-edge output register first. A drive-enable output stands in for a tristate control. The bus value is forced to zero whenever the drivers are off.

Deselects travel down the same two-stage pipeline as reads, so the drivers stay on for one full cycle after a deselect. They switch off only after the second rising edge that follows it. An active-low output enable gates the drivers combinationally. A write command switches the drivers off. A sleep request that is held high for two clock edges puts the block to sleep. While asleep, every command and all array data are ignored and the outputs are off. The first edge that sees the request low wakes the block with an empty pipeline.

The sleep controller has three states, all named in the RTL:
- `ST_RUN` is normal operation. It goes to `ST_ARM` on an edge with the sleep request high.
- `ST_ARM` goes to `ST_SLEEP` if the request is still high and back to `ST_RUN` if it is low.
- `ST_SLEEP` stays put while the request is high and returns to `ST_RUN` when it is low.

Top module: `sram_rd_out_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both command stages and the output register. After that edge, dq_en is 0 and dq_out is 0.
- R2: With pipe_mode=0 (flow-through), take a read (cmd=2'b01) sampled at edge k. Between edges k and k+1, dq_en is 1 and dq_out equals the current rd_data.
- R3: With pipe_mode=1 (registered), take a read sampled at edge k. Between edges k+1 and k+2, dq_en is 1 and dq_out equals the rd_data value that edge k+1 captured. Between edges k and k+1 that read does not drive.
- R4: Take a deselect (cmd=2'b00) sampled at edge k, directly after a read. The drivers stay on until edge k+1 and are off after it, in both modes. In flow-through mode, the held word is the last word read.
- R5: Back-to-back reads deliver one word per cycle with no gap.
- R6: Take a write (cmd=2'b10) sampled at edge k. In either mode, dq_en is 0 between edges k and k+1, even if a read came before it.
- R7: oe_n=1 forces dq_en to 0 and dq_out to 0 within the same cycle. oe_n=0 turns the drivers on only on cycles that carry read data.
- R8: Sleep is entered only after sleep_req is seen high on two consecutive edges. A one-cycle pulse leaves reads unaffected. While asleep, dq_en is 0, and cmd and rd_data have no effect.
- R9: The first edge that samples sleep_req low leaves sleep. A command sampled on that edge is ignored. The pipeline then holds no read, and a read issued after wake-up behaves as in R2.
- R10: The reserved code cmd=2'b11 is treated as a deselect.
- R11: For RECOV_CYC cycles after sleep_req falls, only deselect or read commands may be issued. The user's stimulus must contain no write in that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Command: 00 deselect, 01 read, 10 write, 11 reserved (deselect) |
| rd_data | input | DW | Array read data, valid in the cycle after a read is sampled |
| pipe_mode | input | 1 | 1 selects the registered output path, 0 selects flow-through |
| oe_n | input | 1 | Output enable, active low, combinational gate |
| sleep_req | input | 1 | Sleep request, active high |
| dq_out | output | DW | Output data bus, zero when not driven |
| dq_en | output | 1 | Output driver enable |

## Verification
Each result is checked at a fixed offset from the edge that sampled its command:
- a flow-through read is checked in the very next cycle;
- a registered read is checked one cycle after that;
- a deselect hold lasts exactly one extra cycle past the deselect edge;
- write shut-off is checked in the cycle right after the write edge;
- sleep entry is due two edges after the request rises, and wake-up one edge after it falls.

The bench drives every input just after the falling edge and samples the outputs 2 ns later. Each sample therefore shows the register state from the previous rising edge, combined with the current rd_data and oe_n. The expected values in the table rows are written with that one-edge offset in mind.

// File: rtl/sram_out_pkg.sv
package sram_out_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_ARM   = 2'b01,
        ST_SLEEP = 2'b10
    } slp_e;

endpackage

// File: rtl/rop_sleep_fsm.sv
module rop_sleep_fsm
    import sram_out_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic sleeping
);

    slp_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = sleep_req ? ST_ARM : ST_RUN;
            ST_ARM:   state_d = sleep_req ? ST_SLEEP : ST_RUN;
            ST_SLEEP: state_d = sleep_req ? ST_SLEEP : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        sleeping = (state_q == ST_SLEEP);
    end

endmodule

// File: rtl/rop_cmd_pipe.sv
module rop_cmd_pipe
    import sram_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd,
    input  logic       sleeping,
    output cmd_e       st1,
    output cmd_e       st2
);

    cmd_e cmd_in;
    cmd_e eff;

    always_comb begin
        cmd_in = cmd_e'(cmd);
        if (sleeping) begin
            eff = CMD_DESEL;
        end else begin
            unique case (cmd_in)
                CMD_READ:  eff = CMD_READ;
                CMD_WRITE: eff = CMD_WRITE;
                default:   eff = CMD_DESEL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= CMD_DESEL;
            st2 <= CMD_DESEL;
        end else begin
            st1 <= eff;
            st2 <= sleeping ? CMD_DESEL : st1;
        end
    end

endmodule

// File: rtl/rop_out_stage.sv
module rop_out_stage
    import sram_out_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_mode,
    input  cmd_e          st1,
    input  cmd_e          st2,
    input  logic          sleeping,
    input  logic [DW-1:0] rd_data,
    input  logic          oe_n,
    output logic          drv,
    output logic [DW-1:0] dq_out,
    output logic          dq_en
);

    logic [DW-1:0] out_q;
    logic          drive_ft;
    logic          drive_pp;
    logic [DW-1:0] word;

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (st1 == CMD_READ && !sleeping)
            out_q <= rd_data;
    end

    always_comb begin
        // flow-through: current read, or one-cycle hold after a deselect
        drive_ft = (st1 == CMD_READ) || (st1 == CMD_DESEL && st2 == CMD_READ);
        // registered: older stage carries the read, unless a write is on the bus
        drive_pp = (st2 == CMD_READ) && (st1 != CMD_WRITE);
        drv      = (pipe_mode ? drive_pp : drive_ft) && !sleeping;
        word     = (!pipe_mode && st1 == CMD_READ) ? rd_data : out_q;
        dq_en    = drv && !oe_n;
        dq_out   = dq_en ? word : '0;
    end

endmodule

// File: rtl/sram_rd_out_ctrl.sv
module sram_rd_out_ctrl
    import sram_out_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cmd,
    input  logic [DW-1:0] rd_data,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          sleep_req,
    output logic [DW-1:0] dq_out,
    output logic          dq_en
);

    logic sleeping;
    logic drv;
    cmd_e st1, st2;

    rop_sleep_fsm u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .sleeping  (sleeping)
    );

    rop_cmd_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .sleeping (sleeping),
        .st1      (st1),
        .st2      (st2)
    );

    rop_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .st1       (st1),
        .st2       (st2),
        .sleeping  (sleeping),
        .rd_data   (rd_data),
        .oe_n      (oe_n),
        .drv       (drv),
        .dq_out    (dq_out),
        .dq_en     (dq_en)
    );

    // R1: reset leaves the drivers off
    a_r1_reset_off: assert property (@(posedge clk) rst |=> !drv);

    // R2: flow-through read drives in the cycle after it is sampled
    a_r2_ft_drive: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !sleeping && !$past(rst) && !$past(sleeping)
         && $past(cmd) == CMD_READ) |-> drv);

    // R4: two edges without a read leave nothing to drive
    a_r4_dcd_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd) != CMD_READ && $past(cmd, 2) != CMD_READ)
        |-> !drv);

    // R6: a write turns the bus off on the next cycle
    a_r6_write_off: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE && !sleeping) |=> !dq_en);

    // R8: no driving while asleep
    a_r8_sleep_off: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> !dq_en);

    // R9: wake-up starts with an empty pipeline
    a_r9_wake_empty: assert property (@(posedge clk) disable iff (rst)
        ($past(sleeping) && !sleeping) |-> !drv);

endmodule

// File: tb/tb_sram_rd_out_ctrl.sv
module tb_sram_rd_out_ctrl;

    localparam int DW        = 16;
    localparam int RECOV_CYC = 4;
    localparam int NV        = 26;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd = 2'b00;
    logic [DW-1:0] rd_data = '0;
    logic          pipe_mode = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_en;

    int nchk = 0;
    int nfail = 0;
    int recov = 0;
    int viol = 0;
    logic slp_prev = 1'b0;

    always #10 clk = ~clk;

    sram_rd_out_ctrl #(.DW(DW)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .rd_data(rd_data),
        .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep_req(sleep_req),
        .dq_out(dq_out), .dq_en(dq_en)
    );

    // row: {cmd, rd_data, pipe_mode, oe_n, sleep_req, exp_en, exp_dq}
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 16'h0000, 3'b000, 1'b0, 16'h0000},
        {2'd1, 16'hA001, 3'b000, 1'b1, 16'hA001},
        {2'd0, 16'hA002, 3'b000, 1'b1, 16'hA002},
        {2'd0, 16'h5A5A, 3'b000, 1'b1, 16'hA002},
        {2'd0, 16'h5A5A, 3'b000, 1'b0, 16'h0000},
        {2'd1, 16'h5A5A, 3'b000, 1'b0, 16'h0000},
        {2'd2, 16'hB001, 3'b000, 1'b1, 16'hB001},
        {2'd0, 16'hB002, 3'b000, 1'b0, 16'h0000},
        {2'd1, 16'h5A5A, 3'b000, 1'b0, 16'h0000},
        {2'd1, 16'hC001, 3'b010, 1'b0, 16'h0000},
        {2'd3, 16'hC002, 3'b000, 1'b1, 16'hC002},
        {2'd0, 16'h5A5A, 3'b000, 1'b1, 16'hC002},
        {2'd0, 16'h5A5A, 3'b000, 1'b0, 16'h0000},
        {2'd1, 16'h5A5A, 3'b100, 1'b0, 16'h0000},
        {2'd1, 16'hD001, 3'b100, 1'b0, 16'h0000},
        {2'd1, 16'hD002, 3'b100, 1'b1, 16'hD001},
        {2'd0, 16'hD003, 3'b100, 1'b1, 16'hD002},
        {2'd0, 16'h5A5A, 3'b100, 1'b1, 16'hD003},
        {2'd0, 16'h5A5A, 3'b100, 1'b0, 16'h0000},
        {2'd1, 16'h5A5A, 3'b100, 1'b0, 16'h0000},
        {2'd2, 16'hE001, 3'b100, 1'b0, 16'h0000},
        {2'd0, 16'h5A5A, 3'b100, 1'b0, 16'h0000},
        {2'd1, 16'h5A5A, 3'b100, 1'b0, 16'h0000},
        {2'd0, 16'hE002, 3'b100, 1'b0, 16'h0000},
        {2'd0, 16'h5A5A, 3'b100, 1'b1, 16'hE002},
        {2'd0, 16'h5A5A, 3'b100, 1'b0, 16'h0000}
    };

    task automatic apply(input logic [1:0] c, input logic [DW-1:0] d,
                         input logic m, input logic o, input logic s,
                         input logic r);
        @(negedge clk);
        if (slp_prev && !s) recov = RECOV_CYC;
        else if (recov > 0) recov--;
        if (recov > 0 && c == 2'b10) viol++;
        slp_prev  = s;
        cmd       = c;
        rd_data   = d;
        pipe_mode = m;
        oe_n      = o;
        sleep_req = s;
        rst       = r;
        #2;
    endtask

    task automatic chk(input string tag, input logic e_en, input logic [DW-1:0] e_dq);
        nchk++;
        if (dq_en !== e_en || dq_out !== e_dq) begin
            nfail++;
            $display("FAIL %s: dq_en=%0b dq_out=%h expected dq_en=%0b dq_out=%h",
                     tag, dq_en, dq_out, e_en, e_dq);
        end
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        $display("FAIL watchdog expired, all requirements unchecked");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state
        apply(2'd1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(2'd1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 reset state", 1'b0, 16'h0000);

        // vector table: R2 R4 R6 R7 R10 (flow-through), R3 R4 R5 R6 (registered)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][37:36], VEC[i][35:20], VEC[i][19], VEC[i][18], VEC[i][17], 1'b0);
            if (i < 13) chk($sformatf("R2 R4 R6 R7 R10 vector %0d", i), VEC[i][16], VEC[i][15:0]);
            else        chk($sformatf("R3 R4 R5 R6 vector %0d", i), VEC[i][16], VEC[i][15:0]);
        end

        // R8: sleep entry after two edges, inputs ignored
        apply(2'd1, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R8 idle before sleep", 1'b0, 16'h0000);
        apply(2'd1, 16'hF001, 1'b0, 1'b0, 1'b1, 1'b0); chk("R8 active first edge", 1'b1, 16'hF001);
        apply(2'd1, 16'hF002, 1'b0, 1'b0, 1'b1, 1'b0); chk("R8 active second edge", 1'b1, 16'hF002);
        apply(2'd1, 16'hF003, 1'b0, 1'b0, 1'b1, 1'b0); chk("R8 asleep", 1'b0, 16'h0000);
        apply(2'd1, 16'hF004, 1'b0, 1'b0, 1'b0, 1'b0); chk("R8 asleep read ignored", 1'b0, 16'h0000);
        // R9: wake edge ignores its command, pipeline empty
        apply(2'd1, 16'hF005, 1'b0, 1'b0, 1'b0, 1'b0); chk("R9 wake pipeline empty", 1'b0, 16'h0000);
        apply(2'd0, 16'hF006, 1'b0, 1'b0, 1'b0, 1'b0); chk("R9 read after wake", 1'b1, 16'hF006);
        apply(2'd0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R9 hold after wake", 1'b1, 16'hF006);
        apply(2'd0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R9 off after wake", 1'b0, 16'h0000);

        // R8: one-cycle pulse does not enter sleep
        apply(2'd1, 16'h5A5A, 1'b0, 1'b0, 1'b1, 1'b0); chk("R8 pulse idle", 1'b0, 16'h0000);
        apply(2'd0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0); chk("R8 pulse no sleep", 1'b1, 16'h1234);
        apply(2'd0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R8 pulse hold", 1'b1, 16'h1234);
        apply(2'd0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R8 pulse off", 1'b0, 16'h0000);

        // R1: reset in the middle of a read
        apply(2'd1, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R1 before mid reset", 1'b0, 16'h0000);
        apply(2'd1, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b1); chk("R1 read still driving", 1'b1, 16'h7777);
        apply(2'd0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b1); chk("R1 mid reset clears", 1'b0, 16'h0000);
        apply(2'd0, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0); chk("R1 after mid reset", 1'b0, 16'h0000);

        // R11: no write in the recovery window
        nchk++;
        if (viol != 0) begin
            nfail++;
            $display("FAIL R11: recovery writes=%0d expected=0", viol);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule